// File: doc/BRIEF.md
# Zero-Turnaround Late-Write Synchronous SRAM

A synchronous static memory whose data bus never idles when traffic switches between reads and writes. Address, write enable, byte-lane enables and the three chip enables are all sampled on the rising clock edge. A read returns its word on the output a fixed number of edges later. A write takes its data from the input bus the same number of edges after its address. Read data and write data therefore occupy the same bus slot relative to their address cycles, and a read can follow a write, or a write a read, on consecutive cycles.

A static mode input selects one of two timings. In pipelined mode a read passes through an output register, and write data follows its address by two cycles. In flow-through mode there is no output register, and write data follows by one cycle. A burst-advance input continues the previous operation at the next address inside an aligned group of four. The step order is linear or interleaved, chosen by a static input. Byte writes use 9-bit lanes, and an asynchronous output enable can blank the outputs at any time. Instead of a tristate pin, the block presents the data word together with a drive flag.

Top module: `lw_sram`

## Requirements
- R1: An operation starts only when ce1_n=0, ce2=1 and ce3_n=0 in a cycle with adv=0. A cycle that fails this and has adv=0 neither writes memory nor drives the outputs.
- R2: In pipelined mode (flow_mode=0), a read whose address is sampled at edge k drives its word on dq_out, with dq_drive=1, from edge k+1 up to edge k+2.
- R3: In flow-through mode (flow_mode=1), a read whose address is sampled at edge k drives its word from edge k until edge k+1.
- R4: In pipelined mode, write data is taken from din at edge k+2 for a write address sampled at edge k, and no output is driven for that write.
- R5: In flow-through mode, write data is taken from din at edge k+1 for a write address sampled at edge k, and no output is driven for that write.
- R6: bw_n[i]=0 writes lane i, which is bits [9i+8:9i]. With bw_n[i]=1 the stored lane keeps its value. Byte enables are sampled in the same cycle as the address.
- R7: With order_il=0, a cycle with adv=1 repeats the previous operation type at address {start[ADDR_W-1:2], (start[1:0]+n) mod 4}, where n is the number of advances since the start. The chip enables are ignored in that cycle.
- R8: With order_il=1, the advanced address is {start[ADDR_W-1:2], start[1:0] XOR n}.
- R9: When oe_n=1, dq_drive=0 and dq_out=0 at once, without waiting for a clock edge.
- R10: In pipelined mode, a read issued right after a write to the same address returns the new data, merged per lane with the stored word, even though that write data arrives on the edge that captures the read.
- R11: After reset, dq_drive=0 and no operation is pending.
- R12: An adv=1 cycle that follows a cycle with no operation starts nothing and drives nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| flow_mode | input | 1 | Static: 1 selects flow-through, 0 selects pipelined |
| order_il | input | 1 | Static: 1 selects interleaved bursts, 0 selects linear |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv | input | 1 | Burst advance |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | LANES | Byte-lane write enables, active low |
| addr | input | ADDR_W | Word address |
| din | input | LANES*LANE_W | Late write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drive | output | 1 | High when dq_out carries read data |

## Verification
The hardest case to reach is the pipelined read that lands on the same edge as the data of an earlier write to the same word. It needs a write, a read of the same word on the next cycle, and din presented exactly two edges after the write address. The stimulus table places a partial-lane write directly before a read of the same word, and adds a case where no lanes are enabled. It then replays the same table in both modes, each with its own latency, so both the forwarding path and its absence are checked.

// File: rtl/lw_sram.sv
module lw_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              order_il,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  logic              op_act, op_wr;
  logic [ADDR_W-1:0] op_base;
  logic [1:0]        op_cnt;

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_bw, s2_bw;

  logic [DATA_W-1:0] q_reg;
  logic              q_v;

  wire sel = ~ce1_n & ce2 & ~ce3_n;

  wire              cur_act  = adv ? op_act : sel;
  wire              cur_wr   = adv ? op_wr : ~we_n;
  wire [1:0]        cur_cnt  = adv ? op_cnt + 2'd1 : 2'd0;
  wire [ADDR_W-1:0] cur_base = adv ? op_base : addr;
  wire [1:0]        cur_lo   = order_il ? (cur_base[1:0] ^ cur_cnt)
                                        : (cur_base[1:0] + cur_cnt);
  wire [ADDR_W-1:0] cur_addr = {cur_base[ADDR_W-1:2], cur_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_act  <= 1'b0;
      op_wr   <= 1'b0;
      op_base <= '0;
      op_cnt  <= '0;
      s1_v    <= 1'b0;
      s1_wr   <= 1'b0;
      s1_a    <= '0;
      s1_bw   <= '0;
      s2_v    <= 1'b0;
      s2_wr   <= 1'b0;
      s2_a    <= '0;
      s2_bw   <= '0;
      q_v     <= 1'b0;
      q_reg   <= '0;
    end else begin
      op_act  <= cur_act;
      op_wr   <= cur_wr;
      op_base <= cur_base;
      op_cnt  <= cur_cnt;
      s1_v    <= cur_act;
      s1_wr   <= cur_wr;
      s1_a    <= cur_addr;
      s1_bw   <= ~bw_n;
      s2_v    <= s1_v;
      s2_wr   <= s1_wr;
      s2_a    <= s1_a;
      s2_bw   <= s1_bw;
      q_v     <= s1_v & ~s1_wr;
      q_reg   <= rd_fwd;
    end
  end

  wire              wr_go = flow_mode ? (s1_v & s1_wr) : (s2_v & s2_wr);
  wire [ADDR_W-1:0] wr_a  = flow_mode ? s1_a : s2_a;
  wire [LANES-1:0]  wr_bw = flow_mode ? s1_bw : s2_bw;

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (wr_go && wr_bw[i])
        mem[wr_a][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
  end

  wire [DATA_W-1:0] rd_raw = mem[s1_a];
  wire              fwd    = s2_v & s2_wr & (s2_a == s1_a);
  logic [DATA_W-1:0] rd_fwd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_fwd[g*LANE_W +: LANE_W] = (fwd && s2_bw[g]) ? din[g*LANE_W +: LANE_W]
                                                          : rd_raw[g*LANE_W +: LANE_W];
  end

  wire              v_sel    = flow_mode ? (s1_v & ~s1_wr) : q_v;
  wire [DATA_W-1:0] data_sel = flow_mode ? rd_raw : q_reg;

  assign dq_drive = v_sel & ~oe_n;
  assign dq_out   = dq_drive ? data_sel : '0;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
  parameter int DW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flow_mode,
  input logic          ce1_n,
  input logic          ce2,
  input logic          ce3_n,
  input logic          adv,
  input logic          we_n,
  input logic          oe_n,
  input logic [DW-1:0] dq_out,
  input logic          dq_drive
);
  wire sel = ~ce1_n & ce2 & ~ce3_n;

  p_oe_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dq_drive && dq_out == '0));

  p_reset_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dq_drive);

  p_desel_flow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && !adv && !sel) |=> !dq_drive);

  p_desel_pipe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && !adv && !sel) |=> ##1 !dq_drive);

  p_pipe_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && sel && !adv && we_n) |=> ##1 (oe_n || dq_drive));

  p_flow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && sel && !adv && we_n) |=> (oe_n || dq_drive));

  p_pipe_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && sel && !adv && !we_n) |=> ##1 !dq_drive);

  p_flow_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && sel && !adv && !we_n) |=> !dq_drive);

  p_adv_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && !adv && !sel) ##1 adv |=> !dq_drive);
endmodule

bind lw_sram lw_sram_chk #(.DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv(adv), .we_n(we_n),
  .oe_n(oe_n), .dq_out(dq_out), .dq_drive(dq_drive)
);

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
  logic        clk = 0, rst_n = 0, flow_mode = 0, order_il = 0;
  logic        ce1_n = 1, ce2 = 0, ce3_n = 1, adv = 0, we_n = 1, oe_n = 0;
  logic [1:0]  bw_n = 2'b11;
  logic [7:0]  addr = 0;
  logic [17:0] din = 0;
  logic [17:0] dq_out;
  logic        dq_drive;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lw_sram uut (.*);

  localparam logic [2:0] SEL = 3'b010, OFF = 3'b111;
  // {op[29:28] 0 idle/1 write/2 read, addr[27:20], bw_n[19:18], data[17:0]}
  localparam int NV = 12;
  localparam logic [29:0] VEC [NV] = '{
    {2'd1, 8'h10, 2'b00, 18'h12345},
    {2'd1, 8'h11, 2'b00, 18'h0ABCD},
    {2'd2, 8'h10, 2'b11, 18'h12345},
    {2'd1, 8'h10, 2'b10, 18'h3FFFF},
    {2'd2, 8'h10, 2'b11, 18'h123FF},
    {2'd2, 8'h11, 2'b11, 18'h0ABCD},
    {2'd1, 8'h11, 2'b01, 18'h3FFFF},
    {2'd0, 8'h00, 2'b11, 18'h00000},
    {2'd2, 8'h11, 2'b11, 18'h3FFCD},
    {2'd1, 8'h11, 2'b11, 18'h00000},
    {2'd2, 8'h11, 2'b11, 18'h3FFCD},
    {2'd0, 8'h00, 2'b11, 18'h00000}
  };

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] ce, input logic w, input logic a,
                      input logic [7:0] ad, input logic [1:0] b, input logic [17:0] d);
    @(negedge clk);
    {ce1_n, ce2, ce3_n} = ce;
    we_n = ~w; adv = a; addr = ad; bw_n = b; din = d;
  endtask

  task automatic do_reset(input logic fm);
    @(negedge clk);
    rst_n = 0; {ce1_n, ce2, ce3_n} = OFF; adv = 0; we_n = 1; din = 0;
    flow_mode = fm;
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1 chk("R11 drive after reset", {17'b0, dq_drive}, 18'h0);
  endtask

  task automatic run_table(input logic fm);
    int lat = fm ? 1 : 2;
    for (int i = 0; i < NV + lat; i++) begin
      logic [29:0] e = (i < NV) ? VEC[i] : 30'h0;
      logic [29:0] p = (i >= lat) ? VEC[i-lat] : 30'h0;
      @(negedge clk);
      if (i >= lat) begin
        if (p[29:28] == 2'd2)
          chk(fm ? "R3/R5/R6 table read" : "R2/R4/R6/R10 table read", dq_out, p[17:0]);
        else
          chk(fm ? "R5 no drive on write/idle" : "R4 no drive on write/idle",
              {17'b0, dq_drive}, 18'h0);
      end
      {ce1_n, ce2, ce3_n} = (e[29:28] != 2'd0) ? SEL : OFF;
      we_n = (e[29:28] != 2'd1);
      adv  = 0;
      addr = e[27:20];
      bw_n = e[19:18];
      din  = (p[29:28] == 2'd1) ? p[17:0] : 18'h0;
    end
  endtask

  initial begin
    do_reset(1'b0);
    run_table(1'b0);
    do_reset(1'b1);
    run_table(1'b1);
    do_reset(1'b0);

    // R1: each enable inactive in turn blocks a write
    tick(3'b110, 1, 0, 8'h11, 2'b00, 18'h0);
    tick(3'b000, 1, 0, 8'h11, 2'b00, 18'h0);
    tick(3'b011, 1, 0, 8'h11, 2'b00, 18'h15555);
    chk("R1 deselect no drive", {17'b0, dq_drive}, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h15555);
    chk("R1 deselect no drive", {17'b0, dq_drive}, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h15555);
    tick(SEL, 0, 0, 8'h11, 2'b11, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R1 word unchanged", dq_out, 18'h3FFCD);

    // R9: asynchronous output enable
    oe_n = 1;
    #1 chk("R9 oe off drive", {17'b0, dq_drive}, 18'h0);
    chk("R9 oe off data", dq_out, 18'h0);
    oe_n = 0;
    #1 chk("R9 oe back on", dq_out, 18'h3FFCD);

    // fill 0x20..0x23 for bursts (pipelined late write)
    tick(SEL, 1, 0, 8'h20, 2'b00, 18'h0);
    tick(SEL, 1, 0, 8'h21, 2'b00, 18'h0);
    tick(SEL, 1, 0, 8'h22, 2'b00, 18'h00A00);
    tick(SEL, 1, 0, 8'h23, 2'b00, 18'h00A01);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h00A02);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h00A03);

    // R7: linear burst from 0x22, enables off during advance
    tick(SEL, 0, 0, 8'h22, 2'b11, 18'h0);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    chk("R7 linear beat0", dq_out, 18'h00A02);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    chk("R7 linear beat1", dq_out, 18'h00A03);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R7 linear beat2 wrap", dq_out, 18'h00A00);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R7 linear beat3", dq_out, 18'h00A01);

    // R8: interleaved burst from 0x21
    order_il = 1;
    tick(SEL, 0, 0, 8'h21, 2'b11, 18'h0);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    chk("R8 interleaved beat0", dq_out, 18'h00A01);
    tick(OFF, 0, 1, 8'h0, 2'b11, 18'h0);
    chk("R8 interleaved beat1", dq_out, 18'h00A00);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R8 interleaved beat2", dq_out, 18'h00A03);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R8 interleaved beat3", dq_out, 18'h00A02);
    order_il = 0;

    // R12: advance after an idle cycle
    tick(OFF, 0, 0, 8'h20, 2'b11, 18'h0);
    tick(OFF, 0, 1, 8'h20, 2'b11, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R12 no drive", {17'b0, dq_drive}, 18'h0);
    tick(OFF, 0, 0, 8'h0, 2'b11, 18'h0);
    chk("R12 no drive", {17'b0, dq_drive}, 18'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule